// File: doc/BRIEF.md
# Phase-Numbered Startup Sequencer

This block runs the short sequence that takes a freshly configured device into user operation. A start pulse arms it. A phase counter then moves from 0 up to 6, one step per edge of the startup clock. The clock source is chosen outside the block. Four global controls are released as the counter passes through programmable phase numbers:
- the Done indication
- the global three-state release
- the global write enable
- the global set/reset release

Until write enable is asserted, block RAM cannot be read or written. Each of the three global controls has its own setting, which is one of:
- a phase number
- follow the DoneIn level
- keep its present value (used for partial reconfiguration)

The Done indication has a phase setting only. Once Done is active, the counter holds at the Done phase until the sensed DONE level (DoneIn) is high. DoneIn is either the DONE pin level directly or a copy of it registered one clock later.

The counter can also be stalled at a chosen phase until a DLL-lock input is high. While it is stalled, neither the phase nor any output changes. A drive option makes the block drive DONE high actively instead of leaving it to a pull-up.

Top module: `startup_seq`

## Requirements
- R1: After synchronous reset, and until a start pulse is sampled, `phase_o` is 0, `gts_o` is 1 (outputs three-stated), `gsr_o` is 1 (set/reset held), `gwe_o` is 0 and `done_active_o` is 0.
- R2: A start pulse sampled on edge E arms the sequencer. With no stall, `phase_o` reads 1 after edge E+1 and increases by one per edge up to 6. It then stays at 6.
- R3: A control whose 3-bit code is 1..6 changes to its released value (`gts_o`=0, `gwe_o`=1 or `gsr_o`=0) on the edge where `phase_o` first shows that number. It never changes back while running.
- R4: A control whose code is 7 (follow DoneIn) changes to its released value on the first edge, after arming, at which DoneIn is high.
- R5: A control whose code is 0 (keep) never leaves its present value.
- R6: With `lock_sel_i` = p (0..6) and `dll_locked_i` low, the counter holds at phase p. While it holds, no output changes. Advancing resumes on the first edge at which `dll_locked_i` is high. Code 7 disables the wait.
- R7: `done_active_o` rises on the edge where `phase_o` first reaches the Done phase code (1..6). Codes 0 and 7 act as phase 6.
- R8: At the Done phase, the counter advances only on an edge at which DoneIn is high. DoneIn is `done_pin_i` when `pipe_done_i` is 0, and `done_pin_i` registered once when `pipe_done_i` is 1, which costs one extra stall edge.
- R9: `done_drive_o` is high exactly when `done_active_o` and `drive_done_i` are both high.
- R10: A start pulse while the sequence is armed has no effect. Once armed, the sequence stays armed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock, already selected outside the block |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse that arms the sequence |
| gts_sel_i | input | 3 | Three-state release code: 0 keep, 1..6 phase, 7 follow DoneIn |
| gwe_sel_i | input | 3 | Write enable code, same encoding |
| gsr_sel_i | input | 3 | Set/reset release code, same encoding |
| done_sel_i | input | 3 | Done phase 1..6; 0 and 7 act as 6 |
| lock_sel_i | input | 3 | Lock-wait phase 0..6; 7 means no wait |
| dll_locked_i | input | 1 | DLL lock status |
| pipe_done_i | input | 1 | Register the DONE pin level once before use |
| drive_done_i | input | 1 | Drive DONE high actively once Done is active |
| done_pin_i | input | 1 | Sensed level of the external DONE pin |
| done_active_o | output | 1 | Done indication is active |
| done_drive_o | output | 1 | Active high drive request for the DONE pin |
| gts_o | output | 1 | Global three-state, 1 = outputs disabled |
| gwe_o | output | 1 | Global write enable, 1 = storage writable |
| gsr_o | output | 1 | Global set/reset, 1 = flops held |
| phase_o | output | 3 | Current startup phase |

## Verification
The assertions assume that the five selection codes, `pipe_done_i` and `drive_done_i` stay fixed while the sequence is armed. They may change only while reset is held. The phase-release and Done checks assume this because they compare a sticky output with the current phase decode.

The stimulus respects this assumption: every configuration is applied under reset and then held for a whole run. The runs sweep every Done code against rotating control codes, with the pipelined DONE setting on and off and the DONE pin held low for a few extra edges. A separate sweep covers every lock-wait phase with two lock delays. `start_i` is pulsed a second time mid-run on half of the runs.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    parameter int LAST_PHASE = 6;
    parameter int NUM_CTL    = 3;

    // one spare code above the last phase is needed for "follow" / "no wait"
    localparam int PH_W = $clog2(LAST_PHASE + 2);

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t LAST_PH     = phase_t'(LAST_PHASE);
    localparam phase_t CODE_KEEP   = '0;
    localparam phase_t CODE_FOLLOW = '1;
    localparam phase_t CODE_NOWAIT = '1;

    localparam int CTL_GTS = 0;
    localparam int CTL_GWE = 1;
    localparam int CTL_GSR = 2;

    typedef enum logic [1:0] {
        CTL_KEEP     = 2'd0,
        CTL_AT_PHASE = 2'd1,
        CTL_FOLLOW   = 2'd2
    } ctl_mode_e;

    typedef struct packed {
        ctl_mode_e mode;
        phase_t    phase;
    } ctl_sel_t;

    typedef struct packed {
        logic   advance;
        logic   lock_stall;
        phase_t next;
    } step_t;

    function automatic ctl_sel_t decode_sel(input phase_t code);
        ctl_sel_t r;
        r.phase = code;
        if (code == CODE_KEEP)
            r.mode = CTL_KEEP;
        else if (code == CODE_FOLLOW)
            r.mode = CTL_FOLLOW;
        else
            r.mode = CTL_AT_PHASE;
        return r;
    endfunction

    function automatic phase_t done_phase(input phase_t code);
        return ((code == '0) || (code > LAST_PH)) ? LAST_PH : code;
    endfunction

endpackage

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr
    import startup_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  phase_t lock_sel_i,
    input  logic   dll_locked_i,
    input  phase_t done_ph_i,
    input  logic   done_in_i,
    output phase_t phase_o,
    output logic   running_o,
    output step_t  step_o
);

    phase_t phase_q;
    logic   running_q;
    logic   lock_hit;
    logic   done_hold;
    step_t  step;

    always_comb begin
        lock_hit        = (lock_sel_i != CODE_NOWAIT) && (lock_sel_i == phase_q) && !dll_locked_i;
        done_hold       = (phase_q == done_ph_i) && !done_in_i;
        step.lock_stall = running_q && lock_hit;
        step.advance    = running_q && (phase_q != LAST_PH) && !lock_hit && !done_hold;
        step.next       = phase_q + phase_t'(step.advance);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            running_q <= 1'b0;
        end else begin
            if (start_i && !running_q)
                running_q <= 1'b1;
            phase_q <= step.next;
        end
    end

    assign phase_o   = phase_q;
    assign running_o = running_q;
    assign step_o    = step;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !running_q |-> (phase_q == '0)); // R1

    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST_PH); // R2

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        running_q |=> running_q); // R10

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running_q && (lock_sel_i != CODE_NOWAIT) && (lock_sel_i == phase_q) && !dll_locked_i)
        |=> $stable(phase_q)); // R6

    AST_DONE_GATE: assert property (@(posedge clk) disable iff (rst)
        (running_q && (phase_q == done_ph_i) && !done_in_i) |=> $stable(phase_q)); // R8

endmodule

// File: rtl/startup_done_unit.sv
module startup_done_unit
    import startup_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pipe_i,
    input  logic   drive_i,
    input  logic   done_pin_i,
    input  phase_t done_ph_i,
    input  phase_t phase_i,
    input  logic   advance_i,
    input  phase_t next_i,
    output logic   done_in_o,
    output logic   done_active_o,
    output logic   done_drive_o
);

    logic done_pin_q;
    logic done_active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_pin_q    <= 1'b0;
            done_active_q <= 1'b0;
        end else begin
            done_pin_q <= done_pin_i;
            if (advance_i && (next_i == done_ph_i))
                done_active_q <= 1'b1;
        end
    end

    assign done_in_o     = pipe_i ? done_pin_q : done_pin_i;
    assign done_active_o = done_active_q;
    assign done_drive_o  = done_active_q && drive_i;

    AST_DONE_AT_PHASE: assert property (@(posedge clk) disable iff (rst)
        done_active_q == (phase_i >= done_ph_i)); // R7

endmodule

// File: rtl/startup_release.sv
module startup_release
    import startup_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t sel_i,
    input  logic   running_i,
    input  logic   advance_i,
    input  logic   lock_stall_i,
    input  phase_t next_i,
    input  phase_t phase_i,
    input  logic   done_in_i,
    output logic   active_o
);

    ctl_sel_t dec;
    logic     active_q;
    logic     active_n;

    assign dec = decode_sel(sel_i);

    always_comb begin
        unique case (dec.mode)
            CTL_AT_PHASE: active_n = active_q | (advance_i && (next_i == dec.phase));
            CTL_FOLLOW:   active_n = active_q | (running_i && done_in_i && !lock_stall_i);
            default:      active_n = active_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= 1'b0;
        else
            active_q <= active_n;
    end

    assign active_o = active_q;

    AST_KEEP_FIXED: assert property (@(posedge clk) disable iff (rst)
        (dec.mode == CTL_KEEP) |=> $stable(active_q)); // R5

    AST_AT_PHASE_TRACK: assert property (@(posedge clk) disable iff (rst)
        (dec.mode == CTL_AT_PHASE) |-> (active_q == (phase_i >= dec.phase))); // R3

    AST_FOLLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((dec.mode == CTL_FOLLOW) && $rose(active_q)) |-> $past(done_in_i)); // R4

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] gts_sel_i,
    input  logic [2:0] gwe_sel_i,
    input  logic [2:0] gsr_sel_i,
    input  logic [2:0] done_sel_i,
    input  logic [2:0] lock_sel_i,
    input  logic       dll_locked_i,
    input  logic       pipe_done_i,
    input  logic       drive_done_i,
    input  logic       done_pin_i,
    output logic       done_active_o,
    output logic       done_drive_o,
    output logic       gts_o,
    output logic       gwe_o,
    output logic       gsr_o,
    output logic [2:0] phase_o
);

    phase_t             done_ph;
    phase_t             phase;
    logic               running;
    step_t              step;
    logic               done_in;
    phase_t             sel_arr [NUM_CTL];
    logic [NUM_CTL-1:0] act;

    assign done_ph           = done_phase(phase_t'(done_sel_i));
    assign sel_arr[CTL_GTS]  = phase_t'(gts_sel_i);
    assign sel_arr[CTL_GWE]  = phase_t'(gwe_sel_i);
    assign sel_arr[CTL_GSR]  = phase_t'(gsr_sel_i);

    startup_phase_ctr u_ctr (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .lock_sel_i   (phase_t'(lock_sel_i)),
        .dll_locked_i (dll_locked_i),
        .done_ph_i    (done_ph),
        .done_in_i    (done_in),
        .phase_o      (phase),
        .running_o    (running),
        .step_o       (step)
    );

    startup_done_unit u_done (
        .clk           (clk),
        .rst           (rst),
        .pipe_i        (pipe_done_i),
        .drive_i       (drive_done_i),
        .done_pin_i    (done_pin_i),
        .done_ph_i     (done_ph),
        .phase_i       (phase),
        .advance_i     (step.advance),
        .next_i        (step.next),
        .done_in_o     (done_in),
        .done_active_o (done_active_o),
        .done_drive_o  (done_drive_o)
    );

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        startup_release u_rel (
            .clk          (clk),
            .rst          (rst),
            .sel_i        (sel_arr[g]),
            .running_i    (running),
            .advance_i    (step.advance),
            .lock_stall_i (step.lock_stall),
            .next_i       (step.next),
            .phase_i      (phase),
            .done_in_i    (done_in),
            .active_o     (act[g])
        );
    end

    assign gts_o   = ~act[CTL_GTS];
    assign gwe_o   =  act[CTL_GWE];
    assign gsr_o   = ~act[CTL_GSR];
    assign phase_o = 3'(phase);

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        step.lock_stall |=> ($stable({gts_o, gwe_o, gsr_o, done_active_o}) && $stable(phase_o))); // R6

endmodule

// File: tb/startup_seq_tb.sv
`timescale 1ns/1ps
module startup_seq_tb;

    localparam int RUN_LEN  = 18;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] gts_sel_i = '0, gwe_sel_i = '0, gsr_sel_i = '0, done_sel_i = 3'd4, lock_sel_i = 3'd7;
    logic       dll_locked_i = 1'b0, pipe_done_i = 1'b0, drive_done_i = 1'b0;
    logic       hold = 1'b0;
    logic       done_pin_i;
    logic       done_active_o, done_drive_o, gts_o, gwe_o, gsr_o;
    logic [2:0] phase_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    // DONE pin loops back from the Done output unless the bench holds it low
    assign done_pin_i = hold ? 1'b0 : done_active_o;

    startup_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .gts_sel_i(gts_sel_i), .gwe_sel_i(gwe_sel_i), .gsr_sel_i(gsr_sel_i),
        .done_sel_i(done_sel_i), .lock_sel_i(lock_sel_i), .dll_locked_i(dll_locked_i),
        .pipe_done_i(pipe_done_i), .drive_done_i(drive_done_i), .done_pin_i(done_pin_i),
        .done_active_o(done_active_o), .done_drive_o(done_drive_o),
        .gts_o(gts_o), .gwe_o(gwe_o), .gsr_o(gsr_o), .phase_o(phase_o)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_phase(input int t, input int l, input int w, input int d, input int s);
        int v;
        v = t;
        if (l <= 6 && t > l) v = (t - w > l) ? t - w : l;
        if (v <= d) return v;
        v = (v - s > d) ? v - s : d;
        return (v > 6) ? 6 : v;
    endfunction

    function automatic int exp_act(input int code, input int ph, input int t, input int d, input int s);
        if (code == 0) return 0;
        if (code == 7) return (t >= d + 1 + s) ? 1 : 0;
        return (ph >= code) ? 1 : 0;
    endfunction

    function automatic string ctl_tag(input int code);
        if (code == 0) return "R5";
        if (code == 7) return "R4";
        return "R3";
    endfunction

    task automatic run_case(input int dc, input int gc, input int wc, input int rc,
                            input int lc, input int w, input int pipe, input int h,
                            input bit drv, input bit restart);
        int d, s, ph;
        string ptag;
        d = (dc == 0 || dc > 6) ? 6 : dc;
        s = (lc > 6) ? pipe + h : 0;
        if (lc <= 6)      ptag = "R6 phase";
        else if (s > 0)   ptag = "R8 phase";
        else if (restart) ptag = "R10 phase";
        else              ptag = "R2 phase";

        @(negedge clk);
        rst = 1'b1;
        start_i = 1'b0;
        gts_sel_i = 3'(gc); gwe_sel_i = 3'(wc); gsr_sel_i = 3'(rc);
        done_sel_i = 3'(dc); lock_sel_i = 3'(lc);
        pipe_done_i = pipe[0]; drive_done_i = drv;
        hold = (h > 0); dll_locked_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R1 idle phase", int'(phase_o), 0);
            chk("R1 idle gts", int'(gts_o), 1);
            chk("R1 idle gsr", int'(gsr_o), 1);
            chk("R1 idle gwe", int'(gwe_o), 0);
            chk("R1 idle done", int'(done_active_o), 0);
        end
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        for (int t = 1; t <= RUN_LEN; t++) begin
            @(posedge clk); @(negedge clk);
            ph = exp_phase(t, lc, w, d, s);
            chk(ptag, int'(phase_o), ph);
            chk({ctl_tag(gc), " gts"}, int'(gts_o), 1 - exp_act(gc, ph, t, d, s));
            chk({ctl_tag(wc), " gwe"}, int'(gwe_o), exp_act(wc, ph, t, d, s));
            chk({ctl_tag(rc), " gsr"}, int'(gsr_o), 1 - exp_act(rc, ph, t, d, s));
            chk("R7 done active", int'(done_active_o), (ph >= d) ? 1 : 0);
            chk("R9 done drive", int'(done_drive_o), (ph >= d && drv) ? 1 : 0);
            hold = (h > 0) && (t < d + h);
            dll_locked_i = (t >= lc + w);
            start_i = restart && (t == 2);
        end
        start_i = 1'b0;
    endtask

    initial begin
        // Sweep A: every Done code, rotating control codes, DONE pipelining and pin holds
        for (int dc = 0; dc < 8; dc++)
            for (int g = 0; g < 8; g++)
                for (int p = 0; p < 2; p++)
                    for (int hs = 0; hs < 2; hs++)
                        run_case(dc, g, (g + 3) % 8, (g + 5) % 8, 7, 0, p, hs * 2,
                                 g[0], dc[0]);
        // Sweep B: every lock-wait phase with two lock delays
        for (int lc = 0; lc < 8; lc++)
            for (int wi = 0; wi < 2; wi++)
                run_case(4, 5, 6, 6, lc, 1 + wi * 2, 0, 0, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule